// File: doc/BRIEF.md
# Filtered Interrupt Aggregator

This block gathers several active-low interrupt request lines, one per downstream channel of a bus switch, and merges them into one active-low open-drain interrupt toward the host. Each raw line first passes through a two-flop synchroniser. It then passes through a per-channel glitch filter with separate rejection windows for each direction. A level must hold for `LOW_REJ` clock cycles before a request counts as raised. It must hold for `HIGH_REJ` cycles before a raised request counts as withdrawn. Detection runs on every channel at all times, whether or not that channel is switched through.

The block also presents one filtered status bit per channel to the register slave. That slave samples the bits when the control register is read, placing channel i in register bit 4+i. The status is not latched. It follows the filtered level, so a request clears only when the source device withdraws it.

Each channel filter is a four-state machine. `ST_IDLE` means no request is seen. On a low sample it takes transition `t_lo_seen` to `ST_QUAL_LO`. From `ST_QUAL_LO`, `t_lo_abort` on a high sample returns to `ST_IDLE`, and `t_lo_done` on reaching the low count goes to `ST_ACTIVE`, where the request is pending. From `ST_ACTIVE`, `t_hi_seen` on a high sample moves to `ST_QUAL_HI`. From `ST_QUAL_HI`, `t_hi_abort` on a low sample returns to `ST_ACTIVE`, and `t_hi_done` on reaching the high count goes to `ST_IDLE`. The request is reported as pending in `ST_ACTIVE` and `ST_QUAL_HI`.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every status bit is 0 and `irq_oe` is 0 (output released).
- R2: `irq_oe` is 1 (pull the shared line low) exactly when at least one status bit is 1, i.e. the wired-AND of the active-low channel requests.
- R3: A low pulse on a raw input lasting fewer than `LOW_REJ` clock cycles never sets that channel's status bit or asserts `irq_oe`.
- R4: A raw input held low for at least `LOW_REJ` cycles sets its status bit exactly `LOW_REJ`+2 rising edges after the input falls (two synchroniser stages plus the filter window).
- R5: While a channel is pending, a high pulse shorter than `HIGH_REJ` cycles does not clear its status bit or release `irq_oe`.
- R6: A raw input held high for at least `HIGH_REJ` cycles clears its status bit exactly `HIGH_REJ`+2 rising edges after it rises.
- R7: `status[i]` (register bit 4+i, 1 = pending) reflects only `irq_n_raw[i]`; channels filter independently.
- R8: A qualifying run restarts on any opposite sample, so bursts of sub-window pulses separated by one-cycle gaps are rejected.
- R9: A status bit changes only toward the level that the synchronised input currently shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_n_raw | input | CHANNELS | Raw active-low interrupt requests, one per channel |
| irq_oe | output | 1 | Output enable of the open-drain interrupt; 1 pulls the line low |
| status | output | CHANNELS | Filtered pending flags, bit i = channel i (register bit 4+i) |

## Verification
Low pulses of exactly `LOW_REJ`-1 and `LOW_REJ` cycles separate rejection from acceptance. Sampling one edge before and at the predicted edge pins the latency. The same pair of lengths on the high side, with a pending request, checks the release window. Bursts of sub-window pulses with one-cycle gaps separate a counter that restarts from one that accumulates. A test raising two channels at staggered times shows that each status bit tracks its own line and that the output stays asserted until the last request has gone.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_QUAL_LO = 2'd1,
        ST_ACTIVE  = 2'd2,
        ST_QUAL_HI = 2'd3
    } filt_state_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d_in};
    end

    assign q_out = chain[STAGES-1];

    // Timing part of R4 and R6: output is input delayed by two edges
    assert_sync_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (q_out == $past(d_in, 2)));
endmodule

// File: rtl/irq_filter.sv
module irq_filter
    import irq_agg_pkg::*;
#(
    parameter int LOW_REJ  = 50,
    parameter int HIGH_REJ = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_n,
    output logic pending
);
    localparam int MAXC = (LOW_REJ > HIGH_REJ) ? LOW_REJ : HIGH_REJ;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] LO_LAST = CW'(LOW_REJ - 1);
    localparam logic [CW-1:0] HI_LAST = CW'(HIGH_REJ - 1);

    filt_state_e state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (!in_n) begin            // t_lo_seen
                    state_nx = ST_QUAL_LO;
                    cnt_nx   = CW'(1);
                end
            end
            ST_QUAL_LO: begin
                if (in_n) begin             // t_lo_abort
                    state_nx = ST_IDLE;
                    cnt_nx   = '0;
                end else if (cnt == LO_LAST) begin  // t_lo_done
                    state_nx = ST_ACTIVE;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + CW'(1);
                end
            end
            ST_ACTIVE: begin
                if (in_n) begin             // t_hi_seen
                    state_nx = ST_QUAL_HI;
                    cnt_nx   = CW'(1);
                end
            end
            ST_QUAL_HI: begin
                if (!in_n) begin            // t_hi_abort
                    state_nx = ST_ACTIVE;
                    cnt_nx   = '0;
                end else if (cnt == HI_LAST) begin  // t_hi_done
                    state_nx = ST_IDLE;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + CW'(1);
                end
            end
            default: begin
                state_nx = ST_IDLE;
                cnt_nx   = '0;
            end
        endcase
    end

    always_comb begin
        unique case (state)
            ST_ACTIVE, ST_QUAL_HI: pending = 1'b1;
            default:               pending = 1'b0;
        endcase
    end

    // Independent run-length trackers for the checks below
    logic [CW-1:0] run_lo, run_hi;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_lo <= '0;
            run_hi <= '0;
        end else begin
            run_lo <= in_n  ? '0 : ((run_lo == CW'(MAXC)) ? run_lo : run_lo + CW'(1));
            run_hi <= !in_n ? '0 : ((run_hi == CW'(MAXC)) ? run_hi : run_hi + CW'(1));
        end
    end

    assert_low_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> (run_lo >= CW'(LOW_REJ)));

    assert_high_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pending) |-> (run_hi >= CW'(HIGH_REJ)));

    assert_direction_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pending) |-> (pending == !$past(in_n)));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(MAXC));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
    parameter int CHANNELS = 4,
    parameter int LOW_REJ  = 50,
    parameter int HIGH_REJ = 25
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CHANNELS-1:0] irq_n_raw,
    output logic                irq_oe,
    output logic [CHANNELS-1:0] status
);
    logic [CHANNELS-1:0] irq_n_sync;

    for (genvar g = 0; g < CHANNELS; g++) begin : g_chan
        irq_sync #(.STAGES(2)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d_in  (irq_n_raw[g]),
            .q_out (irq_n_sync[g])
        );
        irq_filter #(.LOW_REJ(LOW_REJ), .HIGH_REJ(HIGH_REJ)) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_n    (irq_n_sync[g]),
            .pending (status[g])
        );
    end

    assign irq_oe = |status;

    // R1: the first cycle out of reset shows nothing pending
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (status == '0));

    // R2: a freshly asserted output must come from a raw line that was low earlier
    assert_oe_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_oe) |-> ($past(irq_n_raw, 3) != '1));
endmodule

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;
    localparam int CH = 4;
    localparam int LR = 50;
    localparam int HR = 25;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CH-1:0] irq_n_raw = '1;
    logic irq_oe;
    logic [CH-1:0] status;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irq_aggregator #(.CHANNELS(CH), .LOW_REJ(LR), .HIGH_REJ(HR)) dut (
        .clk(clk), .rst_n(rst_n), .irq_n_raw(irq_n_raw),
        .irq_oe(irq_oe), .status(status)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic to_negedge();
        @(negedge clk);
    endtask

    task automatic settle();
        to_negedge();
        irq_n_raw = '1;
        edges(HR + 6);
    endtask

    task automatic t_reset();
        check("R1 status", {4'h0, status}, 8'h00);
        check("R1 oe", {7'h0, irq_oe}, 8'h00);
    endtask

    task automatic t_low_glitch();
        for (int c = 0; c < CH; c++) begin
            to_negedge();
            irq_n_raw[c] = 1'b0;
            repeat (LR - 1) @(negedge clk);
            irq_n_raw[c] = 1'b1;
            edges(LR + 4);
            check("R3 status", {4'h0, status}, 8'h00);
            check("R3 oe", {7'h0, irq_oe}, 8'h00);
        end
    endtask

    task automatic t_assert_latency();
        to_negedge();
        irq_n_raw[2] = 1'b0;
        edges(LR + 1);
        check("R4 early", {4'h0, status}, 8'h00);
        edges(1);
        check("R4 set", {4'h0, status}, 8'h04);
        check("R2 oe on", {7'h0, irq_oe}, 8'h01);
    endtask

    task automatic t_high_glitch();
        to_negedge();
        irq_n_raw[2] = 1'b1;
        repeat (HR - 1) @(negedge clk);
        irq_n_raw[2] = 1'b0;
        edges(HR + 4);
        check("R5 held", {4'h0, status}, 8'h04);
        check("R5 oe", {7'h0, irq_oe}, 8'h01);
    endtask

    task automatic t_release_latency();
        to_negedge();
        irq_n_raw[2] = 1'b1;
        edges(HR + 1);
        check("R6 early", {4'h0, status}, 8'h04);
        edges(1);
        check("R6 clear", {4'h0, status}, 8'h00);
        check("R2 oe off", {7'h0, irq_oe}, 8'h00);
    endtask

    task automatic t_channels();
        to_negedge();
        irq_n_raw[0] = 1'b0;
        edges(10);
        to_negedge();
        irq_n_raw[3] = 1'b0;
        edges(LR + 4);
        check("R7 both", {4'h0, status}, 8'h09);
        to_negedge();
        irq_n_raw[0] = 1'b1;
        edges(HR + 4);
        check("R7 ch3 only", {4'h0, status}, 8'h08);
        check("R2 oe last", {7'h0, irq_oe}, 8'h01);
        to_negedge();
        irq_n_raw[3] = 1'b1;
        edges(HR + 4);
        check("R7 none", {4'h0, status}, 8'h00);
        check("R2 oe none", {7'h0, irq_oe}, 8'h00);
    endtask

    task automatic t_chatter();
        to_negedge();
        for (int k = 0; k < 4; k++) begin
            irq_n_raw[1] = 1'b0;
            repeat (LR - 1) @(negedge clk);
            irq_n_raw[1] = 1'b1;
            @(negedge clk);
        end
        edges(LR + 4);
        check("R8 burst", {4'h0, status}, 8'h00);
        check("R9 oe", {7'h0, irq_oe}, 8'h00);
    endtask

    initial begin
        edges(3);
        to_negedge();
        rst_n = 1'b1;
        edges(2);
        t_reset();
        t_low_glitch();
        settle();
        t_assert_latency();
        t_high_glitch();
        t_release_latency();
        settle();
        t_channels();
        settle();
        t_chatter();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule